// File: doc/BRIEF.md
# Nonvolatile Write Commit Sequencer

This block times the internal programming phase that follows a write transaction on a serial memory device. The bus protocol engine reports start and stop conditions, each received data byte, and each moment at which it would like to drive an acknowledge. The sequencer decides whether a finished transaction must be committed to the array. If so, it runs a self-timed interval of a programmable number of clocks and reports busy for that interval. It then sends a single-clock commit strobe to the page buffer.

While the commit interval runs, the sequencer freezes its transaction tracking and withholds every acknowledge grant. A bus master can therefore find out when programming has finished only by repeating start and device-address polls until one is acknowledged. The write-protect input is sampled at the stop. When it is high, the collected bytes are dropped through a discard strobe and no commit interval starts. The standby flag reports that no transaction is open and no commit is running.

Top module: `commit_sequencer`

## Requirements
- R1: After reset, busy_o, commit_o and discard_o are 0 and standby_o is 1, and ack_grant_o follows ack_req_i.
- R2: A stop pulse, seen while idle, that closes a transaction with at least one data byte and with wp_i low, raises busy_o in the clock after the stop is sampled.
- R3: busy_o then stays high for exactly WRITE_CYCLES consecutive clocks.
- R4: commit_o is high for exactly one clock, and it is the first clock in which busy_o is low again.
- R5: While busy_o is high, ack_grant_o is 0 whatever ack_req_i does. Start, stop and data-byte pulses are ignored: they neither extend nor restart the interval, nor open a transaction.
- R6: Once busy_o is low, ack_grant_o equals ack_req_i, so an address poll is acknowledged only after the commit.
- R7: A stop that closes a transaction in which no data byte arrived (an address-only write) leaves busy_o low and gives no commit_o.
- R8: With wp_i high at the stop of a transaction with data bytes, busy_o stays low, no commit_o occurs, and discard_o pulses for exactly one clock, in the clock after the stop.
- R9: standby_o is 0 from the clock after an accepted start until the clock after the next accepted stop, is 0 while busy_o is high, and is 1 otherwise.
- R10: A start pulse discards data bytes counted so far, and a data-byte pulse outside an open transaction is ignored. So start, byte, start, stop and a lone byte then stop each produce no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start condition strobe from the protocol engine |
| stop_i | input | 1 | Stop condition strobe from the protocol engine |
| byte_rx_i | input | 1 | Strobe for a data byte received in a write transaction |
| wp_i | input | 1 | Write protect level, 1 inhibits writes |
| ack_req_i | input | 1 | Protocol engine wants to drive an acknowledge |
| ack_grant_o | output | 1 | Acknowledge allowed on the bus |
| busy_o | output | 1 | Commit interval running |
| commit_o | output | 1 | One-clock strobe that commits the page buffer |
| discard_o | output | 1 | One-clock strobe that drops the page buffer |
| standby_o | output | 1 | No transaction open and no commit running |

## Verification
The bench sweeps data-byte counts from zero to three against both write-protect levels. This separates the three outcomes of a stop: commit, discard and nothing. For each commit it counts the busy clocks and compares the count with the interval parameter. Within that interval it holds acknowledge requests and injects start and stop pulses, so that a design which lets polls through, or restarts or extends the interval, shows up in the grant, in the length or in standby. Two further sequences, a data byte followed by a restart and a lone data byte outside a transaction, show whether byte accounting is tied to the open transaction.

// File: rtl/commit_pkg.sv
package commit_pkg;
    typedef struct packed {
        logic in_txn;
        logic seen;
    } txn_state_t;

    typedef struct packed {
        logic discard;
    } edge_state_t;
endpackage

// File: rtl/commit_txn_tracker.sv
module commit_txn_tracker
    import commit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic byte_i,
    output logic in_txn_o,
    output logic has_data_o
);
    txn_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold_i) begin
            if (byte_i && st_q.in_txn) st_d.seen = 1'b1;
            if (start_i) begin
                st_d.in_txn = 1'b1;
                st_d.seen   = 1'b0;
            end
            if (stop_i) begin
                st_d.in_txn = 1'b0;
                st_d.seen   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_txn_o   = st_q.in_txn;
    assign has_data_o = st_q.seen;

    // R5: bus events are frozen out while the commit runs
    a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(st_q));
endmodule

// File: rtl/commit_timer.sv
module commit_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                t_d.busy = 1'b0;
                t_d.done = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end else if (launch_i) begin
            t_d.busy = 1'b1;
            t_d.cnt  = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o = t_q.busy;
    assign done_o = t_q.done;

    a_r3_count_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && t_q.cnt != '0) |=> busy_o);
    a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/commit_sequencer.sv
module commit_sequencer
    import commit_pkg::*;
#(
    parameter int WRITE_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic byte_rx_i,
    input  logic wp_i,
    input  logic ack_req_i,
    output logic ack_grant_o,
    output logic busy_o,
    output logic commit_o,
    output logic discard_o,
    output logic standby_o
);
    logic        in_txn, has_data, launch, drop;
    edge_state_t e_d, e_q;

    commit_txn_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (busy_o),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .byte_i    (byte_rx_i),
        .in_txn_o  (in_txn),
        .has_data_o(has_data)
    );

    commit_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch_i(launch),
        .busy_o  (busy_o),
        .done_o  (commit_o)
    );

    always_comb begin
        launch    = !busy_o && stop_i && has_data && !wp_i;
        drop      = !busy_o && stop_i && has_data &&  wp_i;
        e_d         = e_q;
        e_d.discard = drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign discard_o   = e_q.discard;
    assign ack_grant_o = ack_req_i && !busy_o;
    assign standby_o   = !busy_o && !in_txn;

    a_r2_launch_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy_o);
    a_r7_empty_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && !has_data) |=> !busy_o);
    a_r8_protect_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && has_data && wp_i) |=> (discard_o && !busy_o));
    a_r9_start_leaves_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i && !busy_o) |=> !standby_o);
endmodule

// File: tb/commit_sequencer_tb.sv
module commit_sequencer_tb;
    localparam int W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, byte_rx_i = 0, wp_i = 0, ack_req_i = 0;
    logic ack_grant_o, busy_o, commit_o, discard_o, standby_o;
    int   n_chk = 0, n_bad = 0;
    bit   finished = 0;

    always #10 clk = ~clk;

    commit_sequencer #(.WRITE_CYCLES(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_rx_i(byte_rx_i), .wp_i(wp_i), .ack_req_i(ack_req_i),
        .ack_grant_o(ack_grant_o), .busy_o(busy_o), .commit_o(commit_o),
        .discard_o(discard_o), .standby_o(standby_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1; tick(); start_i = 0;
    endtask
    task automatic pulse_stop();
        stop_i = 1; tick(); stop_i = 0;
    endtask
    task automatic pulse_byte();
        byte_rx_i = 1; tick(); byte_rx_i = 0;
    endtask

    task automatic run_case(input int nb, input bit wp);
        int n;
        bit expect_commit;
        expect_commit = (nb > 0) && !wp;
        pulse_start();
        check(standby_o == 0, "R9 standby in txn", standby_o, 0);
        for (int i = 0; i < nb; i++) pulse_byte();
        wp_i = wp;
        pulse_stop();
        wp_i = 0;
        if (expect_commit) begin
            check(busy_o == 1, "R2 busy after stop", busy_o, 1);
            check(standby_o == 0, "R9 standby while busy", standby_o, 0);
            n = 0;
            while (busy_o && n < 100) begin
                n++;
                ack_req_i = 1;
                #1;
                check(ack_grant_o == 0, "R5 no grant while busy", ack_grant_o, 0);
                check(commit_o == 0, "R4 no commit while busy", commit_o, 0);
                if (n == 2) begin stop_i = 1; start_i = 1; end
                if (n == 3) byte_rx_i = 1;
                tick();
                stop_i = 0; start_i = 0; byte_rx_i = 0;
            end
            check(n == W, "R3 busy length", n, W);
            check(commit_o == 1, "R4 commit as busy drops", commit_o, 1);
            #1;
            check(ack_grant_o == 1, "R6 poll acked after commit", ack_grant_o, 1);
            ack_req_i = 0;
            tick();
            check(commit_o == 0, "R4 commit one clock", commit_o, 0);
            check(busy_o == 0, "R5 stop during busy ignored", busy_o, 0);
            check(standby_o == 1, "R9 R5 start during busy ignored", standby_o, 1);
        end else begin
            check(busy_o == 0, (nb == 0) ? "R7 empty stop no busy" : "R8 protected no busy", busy_o, 0);
            check(discard_o == ((nb > 0) ? 1 : 0), "R8 discard pulse", discard_o, (nb > 0) ? 1 : 0);
            tick();
            check(discard_o == 0, "R8 discard one clock", discard_o, 0);
            check(commit_o == 0 && busy_o == 0, "R7 R8 no commit", commit_o, 0);
            check(standby_o == 1, "R9 standby after stop", standby_o, 1);
        end
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        check(busy_o == 0 && commit_o == 0 && discard_o == 0, "R1 reset outputs", busy_o, 0);
        check(standby_o == 1, "R1 reset standby", standby_o, 1);
        ack_req_i = 1; #1;
        check(ack_grant_o == 1, "R1 R6 idle grant", ack_grant_o, 1);
        ack_req_i = 0; #1;
        check(ack_grant_o == 0, "R6 grant follows request", ack_grant_o, 0);
        for (int wp = 0; wp < 2; wp++)
            for (int nb = 0; nb < 4; nb++)
                run_case(nb, wp[0]);
        // R10: restart drops bytes counted before it
        pulse_start(); pulse_byte(); pulse_start(); pulse_stop();
        check(busy_o == 0, "R10 restart clears bytes", busy_o, 0);
        tick();
        check(commit_o == 0, "R10 restart no commit", commit_o, 0);
        // R10: lone byte outside a transaction
        pulse_byte(); pulse_stop();
        check(busy_o == 0, "R10 lone byte ignored", busy_o, 0);
        // back-to-back commit still works afterwards
        run_case(1, 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule